// File: doc/BRIEF.md
# Indirect Register Write Bridge

This block lets a host reach a wide register space through a narrow local register port. The host loads a target word address, loads a 32-bit data value, and then writes a command word. Only the command write starts anything. It launches exactly one full-width AXI-Lite write on the master port. The byte address on that port is the stored word address multiplied by four.

A status field in the command register reports progress. Busy is set from the trigger until the write response handshake, and done is set after it. An error flag records a non-OKAY response, and a reject flag records a trigger that arrived while busy. The address and data registers are frozen while a transaction is in flight, so the master port sees stable values. The command word may carry a register-offset or byte-lane field. That field is ignored, because every access is a full 32-bit write.

Top module: `csr_wr_bridge`

## Requirements
- R1: After reset, host reads at offsets 0x0, 0x4 and 0x8 return zero, and awvalid_o, wvalid_o and bready_o are low.
- R2: The address register at offset 0x0 keeps only bits [25:2] of a written value and reads back with all other bits zero.
- R3: Writing 1 to bit 0 of offset 0x8 while idle issues one AXI-Lite write with awaddr_o equal to four times the stored word field. For example, field 0x480480 gives byte address 0x1201200, and field 0x581930 gives 0x16064C0.
- R4: wdata_o equals the data register at offset 0x4, and wstrb_o is 4'hF. Command bits other than bits 0 to 3 have no effect on the issued write.
- R5: awvalid_o and wvalid_o each stay high, with stable payload, until their own handshake, and then drop. The two handshakes may complete in either order.
- R6: Status bit 4 (busy) reads 1 from the edge that accepts the trigger until the B handshake. Status bit 1 (done) then reads 1, and busy and done are never 1 together.
- R7: A B response other than OKAY (2'b00) sets status bit 2 (error) together with done.
- R8: A trigger written while busy sets status bit 3 (reject) and launches nothing. Writes to offsets 0x0 and 0x4 while busy are ignored, and the write in flight keeps its address and data.
- R9: Writing 1 to status bits 1, 2 or 3 clears that bit. A new accepted trigger clears all three.
- R10: Writing the address and data registers without a trigger produces no activity on the master port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_addr_i | input | HOST_AW | Host register byte offset |
| reg_wdata_i | input | DATA_W | Host write data |
| reg_rdata_o | output | DATA_W | Host read data for reg_addr_i (combinational) |
| m_awvalid_o | output | 1 | AXI-Lite write address valid |
| m_awready_i | input | 1 | AXI-Lite write address ready |
| m_awaddr_o | output | ADDR_W | AXI-Lite byte address |
| m_wvalid_o | output | 1 | AXI-Lite write data valid |
| m_wready_i | input | 1 | AXI-Lite write data ready |
| m_wdata_o | output | DATA_W | AXI-Lite write data |
| m_wstrb_o | output | DATA_W/8 | AXI-Lite byte strobes |
| m_bvalid_i | input | 1 | AXI-Lite write response valid |
| m_bready_o | output | 1 | AXI-Lite write response ready |
| m_bresp_i | input | 2 | AXI-Lite write response code |

## Verification
A wrong busy or pending state shows up at the ports in one of two ways. An in-flight write can be relaunched or dropped, which shows as an extra or missing AW handshake. A valid can also fall before its ready, within one cycle of the fault. A status register that drifts from the transaction shows up on the next host read of offset 0x8. Examples are done without busy being cleared, or a stale error or reject flag after a new trigger. A corrupted word field or frozen-register bypass shows up as a wrong awaddr_o or wdata_o in the very handshake that follows. The directed scenarios vary AW-first and W-first ordering and slow responses so that each of these faults shows up.

// File: rtl/csr_wr_bridge_pkg.sv
package csr_wr_bridge_pkg;
  localparam int unsigned IDX_ADDR = 0;
  localparam int unsigned IDX_DATA = 1;
  localparam int unsigned IDX_CMD  = 2;

  localparam int unsigned CMD_GO  = 0;
  localparam int unsigned ST_DONE = 1;
  localparam int unsigned ST_ERR  = 2;
  localparam int unsigned ST_REJ  = 3;
  localparam int unsigned ST_BUSY = 4;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/csr_wr_host_regs.sv
module csr_wr_host_regs
  import csr_wr_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned HOST_AW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [HOST_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                done_i,
  input  logic                resp_err_i,
  output logic                start_o,
  output logic [ADDR_W-3:0]   word_addr_o,
  output logic [DATA_W-1:0]   wdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [HOST_AW-1:0] idx;
  reg_sel_e           sel;
  logic [WORD_W-1:0]  word_q;
  logic [DATA_W-1:0]  data_q;
  logic               busy_q, done_q, err_q, rej_q;
  logic               wr_addr, wr_data, wr_cmd, go, reject;

  assign idx = reg_addr_i >> 2;

  always_comb begin
    if (idx == HOST_AW'(IDX_ADDR))     sel = SEL_ADDR;
    else if (idx == HOST_AW'(IDX_DATA)) sel = SEL_DATA;
    else if (idx == HOST_AW'(IDX_CMD))  sel = SEL_CMD;
    else                                sel = SEL_NONE;
  end

  assign wr_addr = reg_wr_i && (sel == SEL_ADDR);
  assign wr_data = reg_wr_i && (sel == SEL_DATA);
  assign wr_cmd  = reg_wr_i && (sel == SEL_CMD);
  assign go      = wr_cmd && reg_wdata_i[CMD_GO];
  assign start_o = go && !busy_q;
  assign reject  = go && busy_q;

  // address/data frozen while a write is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (wr_addr) word_q <= reg_wdata_i[ADDR_W-1:2];
      if (wr_data) data_q <= reg_wdata_i;
    end
  end

  // later statements take priority over W1C
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      if (wr_cmd) begin
        if (reg_wdata_i[ST_DONE]) done_q <= 1'b0;
        if (reg_wdata_i[ST_ERR])  err_q  <= 1'b0;
        if (reg_wdata_i[ST_REJ])  rej_q  <= 1'b0;
      end
      if (reject) rej_q <= 1'b1;
      if (done_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (resp_err_i) err_q <= 1'b1;
      end
      if (start_o) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        err_q  <= 1'b0;
        rej_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_ADDR: reg_rdata_o[ADDR_W-1:2] = word_q;
      SEL_DATA: reg_rdata_o = data_q;
      SEL_CMD: begin
        reg_rdata_o[ST_DONE] = done_q;
        reg_rdata_o[ST_ERR]  = err_q;
        reg_rdata_o[ST_REJ]  = rej_q;
        reg_rdata_o[ST_BUSY] = busy_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign word_addr_o = word_q;
  assign wdata_o     = data_q;

  assert_busy_done_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q));
  assert_busy_ends_on_resp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(done_i));
  assert_err_from_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(done_i && resp_err_i));
  assert_frozen_while_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(word_q) && $stable(data_q)));
endmodule

// File: rtl/csr_wr_axi_master.sv
module csr_wr_axi_master
  import csr_wr_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ADDR_W-3:0]     word_addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  done_o,
  output logic                  resp_err_o,
  output logic                  m_awvalid_o,
  input  logic                  m_awready_i,
  output logic [ADDR_W-1:0]     m_awaddr_o,
  output logic                  m_wvalid_o,
  input  logic                  m_wready_i,
  output logic [DATA_W-1:0]     m_wdata_o,
  output logic [DATA_W/8-1:0]   m_wstrb_o,
  input  logic                  m_bvalid_i,
  output logic                  m_bready_o,
  input  logic [1:0]            m_bresp_i
);
  logic aw_pend_q, w_pend_q, b_wait_q;
  logic aw_pend_d, w_pend_d;

  assign aw_pend_d = aw_pend_q && !m_awready_i;
  assign w_pend_d  = w_pend_q && !m_wready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      b_wait_q  <= 1'b0;
    end else if (start_i) begin
      aw_pend_q <= 1'b1;
      w_pend_q  <= 1'b1;
    end else begin
      aw_pend_q <= aw_pend_d;
      w_pend_q  <= w_pend_d;
      if ((aw_pend_q || w_pend_q) && !aw_pend_d && !w_pend_d) b_wait_q <= 1'b1;
      else if (b_wait_q && m_bvalid_i) b_wait_q <= 1'b0;
    end
  end

  assign m_awvalid_o = aw_pend_q;
  assign m_awaddr_o  = {word_addr_i, 2'b00};
  assign m_wvalid_o  = w_pend_q;
  assign m_wdata_o   = wdata_i;
  assign m_wstrb_o   = '1;
  assign m_bready_o  = b_wait_q;
  assign done_o      = b_wait_q && m_bvalid_i;
  assign resp_err_o  = m_bresp_i != RESP_OKAY;

  assert_aw_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_awvalid_o && !m_awready_i) |=> (m_awvalid_o && $stable(m_awaddr_o)));
  assert_w_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wvalid_o && !m_wready_i) |=> (m_wvalid_o && $stable(m_wdata_o)));
  assert_no_relaunch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !(aw_pend_q || w_pend_q || b_wait_q));
  assert_aw_drops_after_hs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_awvalid_o && m_awready_i && !start_i) |=> !m_awvalid_o);
endmodule

// File: rtl/csr_wr_bridge.sv
module csr_wr_bridge
  import csr_wr_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned HOST_AW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [HOST_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                m_awvalid_o,
  input  logic                m_awready_i,
  output logic [ADDR_W-1:0]   m_awaddr_o,
  output logic                m_wvalid_o,
  input  logic                m_wready_i,
  output logic [DATA_W-1:0]   m_wdata_o,
  output logic [DATA_W/8-1:0] m_wstrb_o,
  input  logic                m_bvalid_i,
  output logic                m_bready_o,
  input  logic [1:0]          m_bresp_i
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              start, done, resp_err;
  logic [WORD_W-1:0] word_addr;
  logic [DATA_W-1:0] wdata;

  csr_wr_host_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_AW(HOST_AW)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .done_i      (done),
    .resp_err_i  (resp_err),
    .start_o     (start),
    .word_addr_o (word_addr),
    .wdata_o     (wdata)
  );

  csr_wr_axi_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .word_addr_i (word_addr),
    .wdata_i     (wdata),
    .done_o      (done),
    .resp_err_o  (resp_err),
    .m_awvalid_o (m_awvalid_o),
    .m_awready_i (m_awready_i),
    .m_awaddr_o  (m_awaddr_o),
    .m_wvalid_o  (m_wvalid_o),
    .m_wready_i  (m_wready_i),
    .m_wdata_o   (m_wdata_o),
    .m_wstrb_o   (m_wstrb_o),
    .m_bvalid_i  (m_bvalid_i),
    .m_bready_o  (m_bready_o),
    .m_bresp_i   (m_bresp_i)
  );

  assert_bready_only_when_idle_chan_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_bready_o |-> !(m_awvalid_o || m_wvalid_o));
endmodule

// File: tb/csr_wr_bridge_bench.sv
module csr_wr_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int HOST_AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [HOST_AW-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic awvalid, wvalid, bready;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [ADDR_W-1:0] awaddr;
  logic [DATA_W-1:0] wdata;
  logic [3:0] wstrb;
  logic [1:0] bresp = 2'b00;

  int tests = 0, fails = 0;
  int aw_delay = 0, w_delay = 0, b_delay = 0;
  logic [1:0] bresp_cfg = 2'b00;
  int aw_wait = 0, w_wait = 0, b_wait = 0;
  logic aw_seen = 1'b0, w_seen = 1'b0;
  int aw_hs = 0, w_hs = 0, proto_err = 0;
  logic [ADDR_W-1:0] cap_addr = '0;
  logic [DATA_W-1:0] cap_data = '0;
  logic [3:0] cap_strb = '0;
  logic aw_hold = 1'b0, w_hold = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;
  logic [DATA_W-1:0] prev_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_wr_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_AW(HOST_AW)) u_csr_wr_bridge (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .m_awvalid_o(awvalid), .m_awready_i(awready), .m_awaddr_o(awaddr),
    .m_wvalid_o(wvalid), .m_wready_i(wready), .m_wdata_o(wdata), .m_wstrb_o(wstrb),
    .m_bvalid_i(bvalid), .m_bready_o(bready), .m_bresp_i(bresp));

  // AXI-Lite slave model with programmable latencies, plus protocol monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (aw_hold && (!awvalid || awaddr != prev_addr)) proto_err <= proto_err + 1;
      if (w_hold && (!wvalid || wdata != prev_data)) proto_err <= proto_err + 1;
      aw_hold <= awvalid && !awready;
      w_hold  <= wvalid && !wready;
      prev_addr <= awaddr;
      prev_data <= wdata;

      if (awready && awvalid) begin
        awready <= 1'b0; aw_seen <= 1'b1; aw_wait <= 0;
        cap_addr <= awaddr; aw_hs <= aw_hs + 1;
      end else if (awvalid && !aw_seen && !awready) begin
        if (aw_wait >= aw_delay) awready <= 1'b1; else aw_wait <= aw_wait + 1;
      end
      if (wready && wvalid) begin
        wready <= 1'b0; w_seen <= 1'b1; w_wait <= 0;
        cap_data <= wdata; cap_strb <= wstrb; w_hs <= w_hs + 1;
      end else if (wvalid && !w_seen && !wready) begin
        if (w_wait >= w_delay) wready <= 1'b1; else w_wait <= w_wait + 1;
      end
      if (bvalid && bready) begin
        bvalid <= 1'b0; aw_seen <= 1'b0; w_seen <= 1'b0;
      end else if (aw_seen && w_seen && !bvalid) begin
        if (b_wait >= b_delay) begin bvalid <= 1'b1; bresp <= bresp_cfg; b_wait <= 0; end
        else b_wait <= b_wait + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 200; i++) begin
      host_read(4'h8, st);
      if (!st[4]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    host_read(4'h0, v); check(v == 0, "R1 addr reg", v, 0);
    host_read(4'h4, v); check(v == 0, "R1 data reg", v, 0);
    host_read(4'h8, v); check(v == 0, "R1 status", v, 0);
    check({awvalid, wvalid, bready} == 3'b000, "R1 master idle", {awvalid, wvalid, bready}, 0);
  endtask

  task automatic t_no_trigger();
    logic [31:0] v;
    host_write(4'h0, 32'hFFFF_FFFF);
    host_read(4'h0, v); check(v == 32'h03FF_FFFC, "R2 word field mask", v, 32'h03FF_FFFC);
    host_write(4'h4, 32'h1234_5678);
    repeat (10) @(negedge clk);
    check(aw_hs == 0 && w_hs == 0 && !awvalid && !wvalid, "R10 no launch w/o trigger",
          aw_hs + w_hs, 0);
  endtask

  task automatic run_write(input logic [31:0] byte_addr, input logic [31:0] d,
                           input logic [31:0] cmd, input int awd, input int wd,
                           input int bd, input logic [1:0] rsp, input string tag);
    logic [31:0] v;
    int hs0;
    aw_delay = awd; w_delay = wd; b_delay = bd; bresp_cfg = rsp;
    hs0 = aw_hs;
    host_write(4'h0, byte_addr);
    host_write(4'h4, d);
    host_write(4'h8, cmd);
    host_read(4'h8, v);
    check(v[4] == 1'b1 && v[1] == 1'b0, {tag, " R6 busy after trigger"}, v, 32'h10);
    wait_idle();
    host_read(4'h8, v);
    check(v[4] == 1'b0 && v[1] == 1'b1, {tag, " R6 done after resp"}, v, 32'h2);
    check(v[2] == (rsp != 2'b00), {tag, " R7 error bit"}, {31'b0, v[2]}, {31'b0, rsp != 2'b00});
    check(cap_addr == byte_addr[ADDR_W-1:0], {tag, " R3 awaddr"}, 32'(cap_addr), byte_addr);
    check(cap_data == d, {tag, " R4 wdata"}, cap_data, d);
    check(cap_strb == 4'hF, {tag, " R4 wstrb"}, 32'(cap_strb), 32'hF);
    check(aw_hs == hs0 + 1, {tag, " R3 single write"}, aw_hs - hs0, 1);
    check(proto_err == 0, {tag, " R5 valid held until handshake"}, proto_err, 0);
  endtask

  task automatic t_examples();
    // offset bits [11:4] in the command must not matter
    run_write(32'h0120_0000 + 32'h1200, 32'hA5A5_5A5A, 32'h0000_0FF1, 0, 3, 0, 2'b00, "ex1 AW-first");
    run_write(32'h0160_0000 + 32'h64C0, 32'hDEAD_BEEF, 32'h0000_0001, 4, 0, 2, 2'b00, "ex2 W-first");
  endtask

  task automatic t_error_w1c();
    logic [31:0] v;
    run_write(32'h0000_0100, 32'h0000_00FF, 32'h1, 1, 1, 1, 2'b10, "err");
    host_write(4'h8, 32'h4);
    host_read(4'h8, v);
    check(v[2] == 1'b0 && v[1] == 1'b1, "R9 W1C error keeps done", v, 32'h2);
    host_write(4'h8, 32'h2);
    host_read(4'h8, v);
    check(v == 0, "R9 W1C done", v, 0);
  endtask

  task automatic t_busy_reject();
    logic [31:0] v;
    int hs0;
    aw_delay = 1; w_delay = 2; b_delay = 30; bresp_cfg = 2'b00;
    host_write(4'h0, 32'h0000_0440);
    host_write(4'h4, 32'h0BAD_F00D);
    hs0 = aw_hs;
    host_write(4'h8, 32'h1);
    host_write(4'h0, 32'h0000_0880);
    host_write(4'h4, 32'h1111_1111);
    host_write(4'h8, 32'h1);
    host_read(4'h8, v);
    check(v[3] == 1'b1 && v[4] == 1'b1, "R8 reject flagged while busy", v, 32'h18);
    host_read(4'h0, v); check(v == 32'h440, "R8 addr write ignored", v, 32'h440);
    host_read(4'h4, v); check(v == 32'h0BAD_F00D, "R8 data write ignored", v, 32'h0BAD_F00D);
    wait_idle();
    repeat (5) @(negedge clk);
    check(aw_hs == hs0 + 1, "R8 no second launch", aw_hs - hs0, 1);
    check(cap_addr == 26'h440 && cap_data == 32'h0BAD_F00D, "R8 in-flight intact",
          32'(cap_addr), 32'h440);
    host_read(4'h8, v);
    check(v == 32'hA, "R8 done and reject after finish", v, 32'hA);
    // new trigger auto-clears done/reject
    b_delay = 10;
    host_write(4'h8, 32'h1);
    host_read(4'h8, v);
    check(v == 32'h10, "R9 auto-clear on new command", v, 32'h10);
    wait_idle();
    host_write(4'h8, 32'h8);
    host_read(4'h8, v);
    check(v == 32'h2, "R9 W1C reject leaves done", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_trigger();
    t_examples();
    t_error_w1c();
    t_busy_reject();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule